// File: doc/BRIEF.md
# DMA Request Selector and Arbiter

This block sits in front of a four-channel DMA engine and decides which channel performs the next transfer. Each channel owns an 8-bit source-select field that picks one line out of a 256-wide vector of interrupt-style event lines. Timer, external-pin and peripheral data events all count equally as triggers. A rising edge on the selected line, or a software trigger bit, marks the channel as pending. The pending mark is sticky, so a request is never lost while the channel waits for service.

A fixed-priority arbiter looks at the pending channels whenever no transfer is in flight. It grants the lowest-numbered one, presenting both a one-hot grant vector and a binary channel index. The grant is held until the transfer engine returns a done strobe. That strobe clears the served channel's pending mark and frees the arbiter for the next decision. Address generation and bus access belong to the engine behind this block.

Top module: `dma_req_arbiter`

## Requirements
- R1: Channel i (0 to 3) takes its select code from bits [8i+7:8i] of `ch_sel`. When `irq_lines[code]` was 0 in the previous clock cycle and is 1 in the current one, that channel becomes pending. The edge history resets to all zeros.
- R2: A source line that stays high creates no further requests. Only a new 0-to-1 transition does.
- R3: `sw_req[i]` high during a clock edge makes channel i pending, exactly as a hardware edge does.
- R4: A software request and a hardware edge for the same channel in the same cycle produce one pending mark and one transfer.
- R5: When the arbiter is idle and several channels are pending, the lowest channel number is granted. The others stay pending and are granted later in ascending order.
- R6: `grant` is one-hot while `grant_valid` is 1, and `grant_idx` is the binary number of the granted channel. While idle, `grant`, `grant_idx` and `grant_valid` are all zero.
- R7: Once issued, the grant stays unchanged until `xfer_done`. Requests that arrive during a transfer, including ones from lower-numbered channels, wait as pending.
- R8: `xfer_done` while a grant is active clears the granted channel's pending mark, and the grant drops at that same edge. If a new request for that channel arrives in the same cycle, it stays pending. `xfer_done` while idle has no effect.
- R9: A channel whose `ch_enable` bit is 0 ignores its hardware and software requests, and its pending mark is cleared.
- R10: A request taken at clock edge k is granted at edge k+1 if the arbiter is idle. After a release edge, the next grant appears one edge later.
- R11: During reset, `grant`, `grant_idx` and `grant_valid` are zero and no channel is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 256 | Event lines selectable as request sources |
| ch_enable | input | 4 | Per-channel enable |
| ch_sel | input | 32 | Four 8-bit source-select codes, channel 0 in the low byte |
| sw_req | input | 4 | Per-channel software trigger |
| xfer_done | input | 1 | Completion strobe for the granted transfer |
| grant | output | 4 | One-hot grant |
| grant_idx | output | 2 | Index of the granted channel |
| grant_valid | output | 1 | A grant is active |

## Verification
The assertions check the following on every cycle:
- the grant is one-hot and agrees with its index;
- the grant stays stable until done and drops right after done;
- a newly issued grant belongs to a channel that was pending, with no lower channel pending;
- a disabled channel never holds a pending mark.

Edge-versus-level detection, merging of simultaneous software and hardware requests, and the choice of source line by the select code can only be shown by the bench. It drives line patterns, select codes and enables, and compares the grant sequence against a cycle model built from the requirements.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int DMA_NUM_CH  = 4;
  localparam int DMA_SEL_W   = 8;
endpackage

// File: rtl/dma_src_edge.sv
module dma_src_edge #(
  parameter int NUM_SRC = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lines_i,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] hist_q;
  logic [NUM_SRC-1:0] hist_d;

  always_comb begin
    hist_d = lines_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign rise_o = lines_i & ~hist_q;
endmodule

// File: rtl/dma_req_mux.sv
module dma_req_mux #(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 8,
  localparam int NUM_SRC = 1 << SEL_W
) (
  input  logic [NUM_SRC-1:0]      rise_i,
  input  logic [NUM_CH*SEL_W-1:0] sel_i,
  input  logic [NUM_CH-1:0]       en_i,
  input  logic [NUM_CH-1:0]       sw_i,
  output logic [NUM_CH-1:0]       hit_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [SEL_W-1:0] code;
    assign code     = sel_i[g*SEL_W +: SEL_W];
    assign hit_o[g] = en_i[g] & (rise_i[code] | sw_i[g]);
  end
endmodule

// File: rtl/dma_pend_latch.sv
module dma_pend_latch #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] pend_d;
  logic              upd;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      pend_d[i] = en_i[i] ? ((pend_q[i] & ~clr_i[i]) | hit_i[i]) : 1'b0;
    end
    upd = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_fixed_arb.sv
module dma_fixed_arb #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o,
  output logic [NUM_CH-1:0] release_o
);
  logic [NUM_CH-1:0] grant_q, grant_d, pick;
  logic [IDX_W-1:0]  idx_q, idx_d, pick_idx;
  logic              valid_q, valid_d, ld;

  always_comb begin
    pick     = '0;
    pick_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        pick     = '0;
        pick[i]  = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
    grant_d = grant_q;
    idx_d   = idx_q;
    valid_d = valid_q;
    ld      = 1'b0;
    if (valid_q) begin
      if (done_i) begin
        ld      = 1'b1;
        grant_d = '0;
        idx_d   = '0;
        valid_d = 1'b0;
      end
    end else if (|pend_i) begin
      ld      = 1'b1;
      grant_d = pick;
      idx_d   = pick_idx;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (ld) begin
      grant_q <= grant_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  assign grant_o   = grant_q;
  assign idx_o     = idx_q;
  assign valid_o   = valid_q;
  assign release_o = (valid_q && done_i) ? grant_q : '0;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NUM_CH = dma_req_pkg::DMA_NUM_CH,
  parameter int SEL_W  = dma_req_pkg::DMA_SEL_W,
  localparam int NUM_SRC = 1 << SEL_W,
  localparam int IDX_W   = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      irq_lines,
  input  logic [NUM_CH-1:0]       ch_enable,
  input  logic [NUM_CH*SEL_W-1:0] ch_sel,
  input  logic [NUM_CH-1:0]       sw_req,
  input  logic                    xfer_done,
  output logic [NUM_CH-1:0]       grant,
  output logic [IDX_W-1:0]        grant_idx,
  output logic                    grant_valid
);
  logic [NUM_SRC-1:0] rise;
  logic [NUM_CH-1:0]  hit;
  logic [NUM_CH-1:0]  pend_q;
  logic [NUM_CH-1:0]  release_vec;

  dma_src_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_i (irq_lines),
    .rise_o  (rise)
  );

  dma_req_mux #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_mux (
    .rise_i (rise),
    .sel_i  (ch_sel),
    .en_i   (ch_enable),
    .sw_i   (sw_req),
    .hit_o  (hit)
  );

  dma_pend_latch #(.NUM_CH(NUM_CH)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (ch_enable),
    .hit_i  (hit),
    .clr_i  (release_vec),
    .pend_o (pend_q)
  );

  dma_fixed_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend_q),
    .done_i    (xfer_done),
    .grant_o   (grant),
    .idx_o     (grant_idx),
    .valid_o   (grant_valid),
    .release_o (release_vec)
  );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_enable,
  input logic              xfer_done,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] grant,
  input logic [IDX_W-1:0]  grant_idx,
  input logic              grant_valid
);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($countones(grant) == 1) && (grant == (ONE << grant_idx))); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant == '0) && (grant_idx == '0)); // R6

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !xfer_done |=> grant_valid && $stable(grant) && $stable(grant_idx)); // R7

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && xfer_done |=> !grant_valid); // R8

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> (($past(pend) & grant) != '0) &&
                           (($past(pend) & (grant - ONE)) == '0)); // R5

  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(ch_enable)) == '0)); // R9
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_enable   (ch_enable),
  .xfer_done   (xfer_done),
  .pend        (pend_q),
  .grant       (grant),
  .grant_idx   (grant_idx),
  .grant_valid (grant_valid)
);

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;
  localparam int NCH = 4;
  localparam int SW  = 8;
  localparam int NS  = 256;

  logic            clk;
  logic            rst_n;
  logic [NS-1:0]   irq_lines;
  logic [NCH-1:0]  ch_enable;
  logic [NCH*SW-1:0] ch_sel;
  logic [NCH-1:0]  sw_req;
  logic            xfer_done;
  logic [NCH-1:0]  grant;
  logic [1:0]      grant_idx;
  logic            grant_valid;

  int n_chk;
  int n_fail;

  logic [NS-1:0]  m_prev;
  logic [NCH-1:0] m_pend;
  logic [NCH-1:0] m_grant;
  logic           m_valid;

  dma_req_arbiter u_dma_req_arbiter (
    .clk (clk), .rst_n (rst_n), .irq_lines (irq_lines), .ch_enable (ch_enable),
    .ch_sel (ch_sel), .sw_req (sw_req), .xfer_done (xfer_done),
    .grant (grant), .grant_idx (grant_idx), .grant_valid (grant_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [1:0] idx_of(input logic [NCH-1:0] g);
    for (int i = 0; i < NCH; i++) if (g[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic logic [NCH-1:0] lowest(input logic [NCH-1:0] p);
    for (int i = 0; i < NCH; i++) if (p[i]) return NCH'(1) << i;
    return '0;
  endfunction

  task automatic compare(input string tag);
    logic [1:0] eidx;
    eidx  = m_valid ? idx_of(m_grant) : 2'd0;
    n_chk++;
    if (grant !== m_grant || grant_idx !== eidx || grant_valid !== m_valid) begin
      n_fail++;
      $display("FAIL %s: actual grant=%b idx=%0d valid=%b expected grant=%b idx=%0d valid=%b",
               tag, grant, grant_idx, grant_valid, m_grant, eidx, m_valid);
    end
  endtask

  // drive at a falling edge, advance the model to the state after the next rising edge
  task automatic step(input logic [NS-1:0] irq, input logic [NCH-1:0] sw,
                      input logic [NCH-1:0] en, input logic [NCH*SW-1:0] sel,
                      input logic done, input string tag);
    logic [NS-1:0]  rise;
    logic [NCH-1:0] hit, clr, pend_n;
    irq_lines = irq; sw_req = sw; ch_enable = en; ch_sel = sel; xfer_done = done;
    rise = irq & ~m_prev;
    for (int c = 0; c < NCH; c++) begin
      hit[c] = en[c] & (rise[sel[c*SW +: SW]] | sw[c]);
      clr[c] = done & m_valid & m_grant[c];
      pend_n[c] = en[c] ? ((m_pend[c] & ~clr[c]) | hit[c]) : 1'b0;
    end
    if (m_valid) begin
      if (done) begin m_valid = 1'b0; m_grant = '0; end
    end else if (|m_pend) begin
      m_valid = 1'b1; m_grant = lowest(m_pend);
    end
    m_pend = pend_n;
    m_prev = irq;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10: watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  localparam logic [NCH*SW-1:0] SEL0 = {8'd3, 8'd2, 8'd1, 8'd0};

  initial begin
    logic [NCH*SW-1:0] sel;
    logic [NS-1:0]     irq;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; irq_lines = '0; ch_enable = '0; ch_sel = SEL0; sw_req = '0; xfer_done = 1'b0;
    m_prev = '0; m_pend = '0; m_grant = '0; m_valid = 1'b0;
    repeat (3) @(negedge clk);
    compare("R11 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11 after release");

    // R1: channel 2 selects line 5
    sel = {8'd3, 8'd5, 8'd1, 8'd0};
    irq = '0; irq[5] = 1'b1;
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R1 edge on selected line");
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R1 R10 grant after one edge");
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R7 hold");
    step(irq, 4'h0, 4'hF, sel, 1'b1, "R8 release");
    // R2: line still high, no new request
    for (int k = 0; k < 4; k++) step(irq, 4'h0, 4'hF, sel, 1'b0, "R2 level no retrigger");
    // R8: done while idle
    step(irq, 4'h0, 4'hF, sel, 1'b1, "R8 done while idle ignored");
    irq = '0;
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R1 line low");
    // R3 + R4: software and hardware on channel 0 together
    irq[0] = 1'b1;
    step(irq, 4'h1, 4'hF, sel, 1'b0, "R3 R4 merged request");
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R4 single grant");
    step(irq, 4'h0, 4'hF, sel, 1'b1, "R4 release");
    for (int k = 0; k < 3; k++) step(irq, 4'h0, 4'hF, sel, 1'b0, "R4 no second transfer");
    // R5: all four by software
    irq = '0;
    step(irq, 4'hF, 4'hF, sel, 1'b0, "R5 all request");
    for (int k = 0; k < 4; k++) begin
      step(irq, 4'h0, 4'hF, sel, 1'b0, "R5 ascending order");
      step(irq, 4'h0, 4'hF, sel, 1'b1, "R5 R8 release");
    end
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R5 drained");
    // R7: lower channel request during transfer of channel 3
    step(irq, 4'h8, 4'hF, sel, 1'b0, "R7 ch3 request");
    step(irq, 4'h1, 4'hF, sel, 1'b0, "R7 ch0 arrives mid transfer");
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R7 no preempt");
    step(irq, 4'h0, 4'hF, sel, 1'b1, "R7 release");
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R7 waiting ch0 granted");
    // R8: same-channel request during its done cycle stays pending
    step(irq, 4'h1, 4'hF, sel, 1'b1, "R8 re-request on done");
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R8 re-request granted");
    step(irq, 4'h0, 4'hF, sel, 1'b1, "R8 release");
    // R9: disabled channel ignores, disable clears pending
    irq[1] = 1'b1;
    step(irq, 4'h2, 4'hD, sel, 1'b0, "R9 disabled ignores");
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R9 nothing pending");
    step(irq, 4'h6, 4'hF, sel, 1'b0, "R9 ch1 ch2 request");
    step(irq, 4'h0, 4'hB, sel, 1'b0, "R9 ch1 granted, ch2 disabled");
    step(irq, 4'h0, 4'hF, sel, 1'b1, "R9 release");
    for (int k = 0; k < 3; k++) step(irq, 4'h0, 4'hF, sel, 1'b0, "R9 ch2 pending cleared");
    // R1: select code 255
    sel = {8'd255, 8'd2, 8'd1, 8'd0};
    irq = '0;
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R1 setup");
    irq[255] = 1'b1;
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R1 top line");
    step(irq, 4'h0, 4'hF, sel, 1'b0, "R1 ch3 granted");
    step(irq, 4'h0, 4'hF, sel, 1'b1, "R1 release");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [NCH-1:0] en, sw;
      logic done;
      if (n % 200 == 0) begin
        for (int c = 0; c < NCH; c++)
          sel[c*SW +: SW] = ($urandom % 6 == 0) ? 8'd255 : 8'($urandom % 8);
      end
      for (int b = 0; b < 8; b++) if ($urandom % 5 == 0) irq[b] = ~irq[b];
      if ($urandom % 5 == 0) irq[255] = ~irq[255];
      en   = ($urandom % 10 != 0) ? 4'hF : 4'($urandom);
      sw   = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
      done = m_valid ? ($urandom % 3 == 0) : ($urandom % 10 == 0);
      step(irq, sw, en, sel, done, "R5 R7 R8 R9 R10 random");
    end

    summary();
    $finish;
  end
endmodule